// File: doc/BRIEF.md
# Keyboard Controller Port Trap

This block watches host-side I/O traffic aimed at the two legacy keyboard controller ports, the data port and the command port. Each access is decoded into one of four kinds: data-port read, data-port write, command-port read or command-port write. Each kind sets a sticky status flag of its own. A flag is recorded whether or not it is enabled. The interrupt to the system-management handler is raised only for flags whose enable is set.

For an enabled access kind, the block does three things. It keeps the chip select of the external keyboard controller low, so the trapped access never reaches that device. It raises the interrupt. It holds back the target-ready handshake until the interrupt has been visible for a set number of clocks, so the processor sees the interrupt before the cycle completes. A pass-through bit lets every keyboard-port access reach the external controller while the status flags keep recording.

Software reads and clears the flags and writes the enables through a small register port. Register 0 holds the status flags and is write-one-to-clear. Register 1 holds the enables and the pass-through bit.

Top module: `kbd_trap_unit`

## Requirements
- R1: Status bit 0 records a data-port read, bit 1 a data-port write, bit 2 a command-port read and bit 3 a command-port write. The data port is 60h and the command port is 64h. Status is read at `cfg_addr`=0 in `cfg_rdata[3:0]`.
- R2: A matching I/O access sets its status bit at the first clock edge of the access, whatever the state of its enable bit.
- R3: `trap_irq` is high exactly when at least one status bit and its enable bit are both set. Enable bits are `cfg_rdata[3:0]` at `cfg_addr`=1, using the same bit order as status.
- R4: For an access whose enable bit is set, `bus_ready` stays low until `trap_irq` has been high for IRQ_HOLD (default 1) earlier clocks, and `trap_irq` is high when `bus_ready` rises.
- R5: `kbc_sel` is high during an I/O access to port 60h or 64h unless that access kind's enable bit is set.
- R6: When the pass-through bit is set (register 1, bit 4), `kbc_sel` is high for every keyboard-port I/O access, including enabled ones. Status still latches.
- R7: Writing register 0 clears each status bit whose `cfg_wdata` bit is 1. Bits written with 0 keep their value.
- R8: When a clear and a new event for the same status bit fall on the same clock edge, the bit ends up set.
- R9: An access to any other address, or a non-I/O access, changes no status bit and never raises `kbc_sel`.
- R10: After reset, all status, enable and pass-through bits read 0, and `trap_irq` and `kbc_sel` are low.
- R11: An access that is not trapped gets `bus_ready` ACK_LAT (default 1) clocks after its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus access in progress; held until `bus_ready` |
| bus_is_io | input | 1 | Access is an I/O cycle |
| bus_write | input | 1 | Access is a write (0 = read) |
| bus_addr | input | ADDR_W | Access address |
| bus_ready | output | 1 | Target ready; the access completes at the clock edge where this is high |
| kbc_sel | output | 1 | Chip select to the external keyboard controller |
| trap_irq | output | 1 | System-management interrupt request |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 = status, 1 = enables |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data, combinational from `cfg_addr` |

## Verification
The bench sends random accesses to the two trapped ports, to a neighbouring address and to arbitrary addresses. Each access is either an I/O cycle or a non-I/O cycle. These accesses are interleaved with random enable, pass-through and clear writes, so each of the four access kinds is tried with its enable on and off and with the pass-through bit on and off.

The bench measures ready latency, chip select, interrupt and status against a model:
- The ready latency separates trapped accesses from untrapped ones.
- It also separates a first trap, which has to wait for the interrupt, from a trap that arrives while the interrupt is already high.
- Accesses to non-keyboard addresses and non-I/O cycles show that decoding depends on both the address and the cycle type.

Directed cases cover the reset state, a partial clear, and a clear that lands on the same edge as a new event.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;
   localparam int NSRC     = 4;
   localparam int PASS_BIT = NSRC;

   // bit order of the status and enable vectors
   typedef enum logic [1:0] {
      SRC_RD_DATA = 2'd0,
      SRC_WR_DATA = 2'd1,
      SRC_RD_CMD  = 2'd2,
      SRC_WR_CMD  = 2'd3
   } trap_src_e;

   typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/kbd_trap_decode.sv
module kbd_trap_decode
   import kbd_trap_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int unsigned DATA_PORT = 'h60,
   parameter int unsigned CMD_PORT  = 'h64
) (
   input  logic              valid,
   input  logic              is_io,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   output src_vec_t          hit,
   output logic              kbc_port
);
   logic data_m;
   logic cmd_m;
   logic io_cyc;

   assign io_cyc   = valid & is_io;
   assign data_m   = (addr == ADDR_W'(DATA_PORT));
   assign cmd_m    = (addr == ADDR_W'(CMD_PORT));
   assign kbc_port = io_cyc & (data_m | cmd_m);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam bit IS_CMD = (i >= 2);
      localparam bit IS_WR  = (i % 2) == 1;
      logic port_m;
      logic dir_m;
      if (IS_CMD) begin : g_cmd
         assign port_m = cmd_m;
      end else begin : g_data
         assign port_m = data_m;
      end
      if (IS_WR) begin : g_wr
         assign dir_m = write;
      end else begin : g_rd
         assign dir_m = ~write;
      end
      assign hit[i] = io_cyc & port_m & dir_m;
   end
endmodule

// File: rtl/kbd_trap_regs.sv
module kbd_trap_regs
   import kbd_trap_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  src_vec_t          hit,
   input  logic              cfg_wr,
   input  logic              cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output src_vec_t          status,
   output src_vec_t          en,
   output logic              pass,
   output logic [DATA_W-1:0] cfg_rdata
);
   src_vec_t clr;

   assign clr = (cfg_wr && !cfg_addr) ? cfg_wdata[NSRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         en     <= '0;
         pass   <= 1'b0;
      end else begin
         // a new event overrides a clear on the same edge
         status <= (status & ~clr) | hit;
         if (cfg_wr && cfg_addr) begin
            en   <= cfg_wdata[NSRC-1:0];
            pass <= cfg_wdata[PASS_BIT];
         end
      end
   end

   assign cfg_rdata = cfg_addr ? DATA_W'({pass, en}) : DATA_W'(status);
endmodule

// File: rtl/kbd_trap_ready.sv
module kbd_trap_ready #(
   parameter int ACK_LAT  = 1,
   parameter int IRQ_HOLD = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic trapped,
   input  logic irq,
   output logic ready
);
   localparam int MAXC  = ((ACK_LAT > IRQ_HOLD) ? ACK_LAT : IRQ_HOLD) + 1;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAXC);

   logic [CNT_W-1:0] age;
   logic [CNT_W-1:0] irq_cnt;
   logic             lat_ok;
   logic             hold_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age     <= '0;
         irq_cnt <= '0;
      end else if (!valid || ready) begin
         age     <= '0;
         irq_cnt <= '0;
      end else begin
         if (age != CMAX) age <= age + 1'b1;
         if (irq && irq_cnt != CMAX) irq_cnt <= irq_cnt + 1'b1;
      end
   end

   assign lat_ok  = (age >= CNT_W'(ACK_LAT));
   assign hold_ok = (irq_cnt >= CNT_W'(IRQ_HOLD)) & irq;
   assign ready   = valid & lat_ok & (~trapped | hold_ok);
endmodule

// File: rtl/kbd_trap_unit.sv
module kbd_trap_unit
   import kbd_trap_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int unsigned DATA_PORT = 'h60,
   parameter int unsigned CMD_PORT  = 'h64,
   parameter int          ACK_LAT   = 1,
   parameter int          IRQ_HOLD  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_is_io,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              bus_ready,
   output logic              kbc_sel,
   output logic              trap_irq,
   input  logic              cfg_wr,
   input  logic              cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata
);
   if (DATA_W < NSRC + 1) begin : g_bad_dw
      $error("DATA_W must hold the enables and the pass-through bit");
   end
   if (IRQ_HOLD < 1) begin : g_bad_hold
      $error("IRQ_HOLD must be at least one clock");
   end
   if (ACK_LAT < 0) begin : g_bad_lat
      $error("ACK_LAT must not be negative");
   end
   if (DATA_PORT >= (1 << ADDR_W) || CMD_PORT >= (1 << ADDR_W)) begin : g_bad_port
      $error("port addresses exceed ADDR_W");
   end

   src_vec_t acc_hit;
   src_vec_t stat_q;
   src_vec_t en_q;
   logic     pass_q;
   logic     kbc_port;
   logic     trapped;

   kbd_trap_decode #(
      .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
   ) u_dec (
      .valid(bus_valid), .is_io(bus_is_io), .write(bus_write),
      .addr(bus_addr), .hit(acc_hit), .kbc_port(kbc_port)
   );

   kbd_trap_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .hit(acc_hit),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .status(stat_q), .en(en_q), .pass(pass_q), .cfg_rdata(cfg_rdata)
   );

   assign trapped  = |(acc_hit & en_q);
   assign trap_irq = |(stat_q & en_q);
   assign kbc_sel  = kbc_port & (pass_q | ~trapped);

   kbd_trap_ready #(.ACK_LAT(ACK_LAT), .IRQ_HOLD(IRQ_HOLD)) u_rdy (
      .clk(clk), .rst_n(rst_n), .valid(bus_valid),
      .trapped(trapped), .irq(trap_irq), .ready(bus_ready)
   );
endmodule

// File: rtl/kbd_trap_chk.sv
module kbd_trap_chk
   import kbd_trap_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_is_io,
   input logic              bus_ready,
   input logic              kbc_sel,
   input logic              trap_irq,
   input logic              cfg_wr,
   input logic              cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input src_vec_t          hit,
   input src_vec_t          status,
   input src_vec_t          en,
   input logic              pass
);
   // R2: a decoded access leaves its flag set after the edge
   p_set_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((status & $past(hit)) == $past(hit)));

   // R7: without a status write no flag drops
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && !cfg_addr) |=> ((status & $past(status)) == $past(status)));

   // R3: interrupt needs a latched flag
   p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_irq |-> (|status));

   // R4: interrupt visible for a clock before a trapped cycle completes
   p_irq_before_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ready && (|(hit & en))) |-> (trap_irq && $past(trap_irq)));

   // R5: no chip select on an enabled access without pass-through
   p_cs_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      kbc_sel |-> (pass || !(|(hit & en))));

   // R9: chip select only during an I/O cycle
   p_cs_io_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      kbc_sel |-> (bus_valid && bus_is_io));

   // R11: ready only inside an access
   p_ready_in_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> bus_valid);
endmodule

bind kbd_trap_unit kbd_trap_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_is_io(bus_is_io),
   .bus_ready(bus_ready), .kbc_sel(kbc_sel), .trap_irq(trap_irq),
   .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
   .hit(acc_hit), .status(stat_q), .en(en_q), .pass(pass_q)
);

// File: tb/sim_kbd_trap_unit.sv
module sim_kbd_trap_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_is_io = 1'b0, bus_write = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_ready, kbc_sel, trap_irq;
   logic        cfg_wr = 1'b0, cfg_addr = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [3:0] exp_status = '0, exp_en = '0;
   bit         exp_pass = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   kbd_trap_unit u0 (.*);

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] src_of(bit io, bit wr, logic [15:0] a);
      logic [3:0] v = '0;
      if (io && a == 16'h60) v[wr ? 1 : 0] = 1'b1;
      if (io && a == 16'h64) v[wr ? 3 : 2] = 1'b1;
      return v;
   endfunction

   task automatic check_state(input string tag);
      cfg_addr = 1'b0; #1;
      check(cfg_rdata[3:0] == exp_status, {tag, " R1 status"}, cfg_rdata, exp_status);
      check(trap_irq == |(exp_status & exp_en), {tag, " R3 irq"}, trap_irq, |(exp_status & exp_en));
   endtask

   task automatic access(input bit io, input bit wr, input logic [15:0] a);
      logic [3:0] src = src_of(io, wr, a);
      bit trapped = |(src & exp_en);
      bit kport = io && (a == 16'h60 || a == 16'h64);
      bit exp_cs = kport && (exp_pass || !trapped);
      int exp_lat = trapped ? ((|(exp_status & exp_en)) ? 1 : 2) : 1;
      int n = 0;
      @(negedge clk);
      bus_valid = 1'b1; bus_is_io = io; bus_write = wr; bus_addr = a;
      #1;
      check(kbc_sel == exp_cs, exp_pass ? "R6 kbc_sel" : (kport ? "R5 kbc_sel" : "R9 kbc_sel"),
            kbc_sel, exp_cs);
      while (!bus_ready && n < 10) begin
         @(negedge clk); n++; #1;
      end
      check(n == exp_lat, trapped ? "R4 ready latency" : "R11 ready latency", n, exp_lat);
      if (trapped) check(trap_irq == 1'b1, "R4 irq at ready", trap_irq, 1);
      @(negedge clk);
      bus_valid = 1'b0;
      exp_status |= src;
      check_state(src == 0 ? "R9" : "R2");
   endtask

   task automatic cfg_write(input bit adr, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = adr; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_addr = 1'b0;
      if (adr) begin exp_en = d[3:0]; exp_pass = d[4]; end
      else exp_status &= ~d[3:0];
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h1A2B));
      #3;
      check(trap_irq == 0 && kbc_sel == 0, "R10 outputs in reset", {trap_irq, kbc_sel}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cfg_addr = 1'b0; #1;
      check(cfg_rdata == 0, "R10 status reset", cfg_rdata, 0);
      cfg_addr = 1'b1; #1;
      check(cfg_rdata == 0, "R10 enable reset", cfg_rdata, 0);
      cfg_addr = 1'b0;

      // directed: each kind with enables off, then on
      access(1, 0, 16'h60); access(1, 1, 16'h60);
      access(1, 0, 16'h64); access(1, 1, 16'h64);
      access(0, 0, 16'h60); access(1, 0, 16'h61);
      cfg_write(0, 8'h05);              // R7 partial clear
      check_state("R7");
      cfg_write(0, 8'h0F);
      cfg_write(1, 8'h0F);
      cfg_addr = 1'b1; #1;
      check(cfg_rdata == 8'h0F, "R3 enable readback", cfg_rdata, 8'h0F);
      cfg_addr = 1'b0;
      access(1, 1, 16'h64);             // first trap waits for irq
      access(1, 0, 16'h60);             // irq already high
      cfg_write(1, 8'h1F);              // R6 pass-through
      access(1, 1, 16'h60);

      // R8: clear and new event on the same edge
      cfg_write(1, 8'h00);
      @(negedge clk);
      bus_valid = 1'b1; bus_is_io = 1'b1; bus_write = 1'b0; bus_addr = 16'h60;
      cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h0F;
      @(negedge clk);
      cfg_wr = 1'b0; bus_valid = 1'b0;
      exp_status = 4'b0001;
      #1;
      check(cfg_rdata[3:0] == 4'b0001, "R8 set wins over clear", cfg_rdata, 1);

      for (int it = 0; it < 400; it++) begin
         int op = $urandom % 6;
         if (op < 4) begin
            int s = $urandom % 4;
            logic [15:0] a = (s == 0) ? 16'h60 : (s == 1) ? 16'h64 : (s == 2) ? 16'h61 : 16'($urandom);
            access(($urandom % 4) != 0, $urandom % 2, a);
         end else if (op == 4) begin
            cfg_write(1, 8'($urandom % 32));
         end else begin
            cfg_write(0, 8'($urandom % 16));
            check_state("R7");
         end
      end
      done = 1;
      finish_run();
   end
endmodule